// File: doc/BRIEF.md
# Incremental Control-Code Test Sequencer

This block is a self-test pattern source and pattern checker that works at the byte level, on the near side of an 8b/10b encoder and the far side of an 8b/10b decoder. Each symbol is an 8-bit value with a control flag. The generator repeats a frame of 268 symbols without a break. The frame opens with the comma K28.5 and then K27.7. A ramp of all 256 data byte values follows. Ten further control codes close the frame.

The checker takes decoded bytes and their control flags. It waits for a comma and then compares every later symbol with the position it expects in the frame. It reports three things: whether it is locked, a one-cycle pulse on each mismatch, and a count of clean frames. The lane count can be set to 2 for the double-width (20-bit encoded) path. In that case two consecutive frame symbols travel in each cycle, and the earlier one sits in the low byte.

Top module: `inc_seq`

## Requirements
- R1: After reset, lane 0 of the generator shows K28.5 (value 0xBC, flag 1), and the checker shows lock 0, error 0 and a frame count of 0.
- R2: The generator emits the frame one symbol per lane per clock. Position 0 is 0xBC/flag 1 and position 1 is 0xFB/flag 1. Positions 2 to 257 carry the data values 0x00 to 0xFF with flag 0. Positions 258 to 267 are flag-1 codes in this order: 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xDC, 0xFC, 0xF7, 0xFE, 0xFD. The frame then restarts at position 0.
- R3: With two lanes, bits [7:0] and flag bit 0 carry the earlier symbol, and bits [15:8] and flag bit 1 carry the next one.
- R4: While unlocked, the checker ignores every symbol that is not 0xBC with flag 1. Lock and error both stay 0. A 0xBC sent with flag 0 does not lock it.
- R5: Lock goes to 1 in the cycle after a comma is sampled, and it stays at 1 while the symbols that follow match the frame.
- R6: When a locked checker samples a symbol that differs from the expected one in value, error is 1 for exactly the following cycle and lock drops. The exception is a mismatching symbol that is itself a comma: lock then stays at 1, and K27.7 is expected next.
- R7: The frame counter rises by 1 in the cycle after a matching 0xFD at position 267 is sampled while locked. A frame that had an error is not counted, and the counter wraps at its width.
- R8: With two lanes, the checker finds a comma in either lane and handles the low lane before the high lane within a cycle.
- R9: A symbol that has the expected value but the wrong control flag counts as a mismatch under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_data | output | 8*LANES | Generated symbol values, lane 0 in the low byte |
| gen_ctrl | output | LANES | Control flag of each generated symbol |
| chk_data | input | 8*LANES | Decoded symbol values to check, lane 0 in the low byte |
| chk_ctrl | input | LANES | Control flag of each decoded symbol |
| chk_lock | output | 1 | Checker is synchronized to the frame |
| chk_err | output | 1 | One-cycle pulse after a mismatching symbol |
| chk_frames | output | CNT_W | Count of error-free frames |

## Verification
Every generator position is checked over several whole frames, including the wrap from 0xFD back to the comma. A wrong tail order or a ramp that is off by one would appear there. Bytes equal to 0xBC that arrive with the flag cleared must not lock the checker. A flag-only error must be caught, which a value-only comparison would miss. A frame holding a corrupted byte must not be counted, which a counter driven only by seeing 0xFD would get wrong. A comma that arrives out of place must raise an error and still leave the checker locked. In the two-lane build the bench skews the stream by one symbol, so the comma falls in the high lane and the frame ends in the low lane. This case fails if the lanes are handled in the wrong order or the search looks only at lane 0.

// File: rtl/inc_seq_pkg.sv
// Package: frame constants, symbol type and the position-to-symbol map
// shared by the generator and the checker.
// Assumes 8-bit symbols; the ramp spans every value of one symbol.
package inc_seq_pkg;

    localparam int SYM_W     = 8;
    localparam int HEAD_LEN  = 2;
    localparam int RAMP_LEN  = 1 << SYM_W;
    localparam int TAIL_LEN  = 10;
    localparam int FRAME_LEN = HEAD_LEN + RAMP_LEN + TAIL_LEN;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int LAST_POS  = FRAME_LEN - 1;
    localparam int TAIL_POS  = HEAD_LEN + RAMP_LEN;

    localparam logic [SYM_W-1:0] K_COMMA  = 8'hBC;
    localparam logic [SYM_W-1:0] K_SECOND = 8'hFB;

    typedef struct packed {
        logic             k;
        logic [SYM_W-1:0] v;
    } sym_t;

    // Control code at a given slot of the closing list.
    function automatic logic [SYM_W-1:0] tail_code(input logic [3:0] n);
        logic [SYM_W-1:0] c;
        case (n)
            4'd0:    c = 8'h1C;
            4'd1:    c = 8'h3C;
            4'd2:    c = 8'h5C;
            4'd3:    c = 8'h7C;
            4'd4:    c = 8'h9C;
            4'd5:    c = 8'hDC;
            4'd6:    c = 8'hFC;
            4'd7:    c = 8'hF7;
            4'd8:    c = 8'hFE;
            default: c = 8'hFD;
        endcase
        return c;
    endfunction

    // Symbol at a frame position (position below FRAME_LEN).
    function automatic sym_t sym_at(input logic [IDX_W-1:0] idx);
        sym_t s;
        if (idx == '0) begin
            s.k = 1'b1;
            s.v = K_COMMA;
        end else if (idx == IDX_W'(1)) begin
            s.k = 1'b1;
            s.v = K_SECOND;
        end else if (idx < IDX_W'(TAIL_POS)) begin
            s.k = 1'b0;
            s.v = SYM_W'(idx - IDX_W'(HEAD_LEN));
        end else begin
            s.k = 1'b1;
            s.v = tail_code(4'(idx - IDX_W'(TAIL_POS)));
        end
        return s;
    endfunction

endpackage

// File: rtl/inc_seq_gen.sv
// Generator: walks the frame position LANES at a time and shows one
// symbol per lane, earliest in lane 0.
// Assumes FRAME_LEN is a multiple of LANES, so a lane never runs past
// the end of the frame within one cycle.
module inc_seq_gen
    import inc_seq_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [LANES*SYM_W-1:0] data,
    output logic [LANES-1:0]       ctrl
);

    localparam logic [IDX_W-1:0] STEP = IDX_W'(LANES);
    localparam logic [IDX_W-1:0] WRAP = IDX_W'(FRAME_LEN - LANES);

    logic [IDX_W-1:0] idx_q;

    // Frame position of lane 0; wraps to the comma after the last group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_q >= WRAP) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_q + STEP;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sym_t lane_s;
        assign lane_s                  = sym_at(idx_q + IDX_W'(l));
        assign data[l*SYM_W +: SYM_W]  = lane_s.v;
        assign ctrl[l]                 = lane_s.k;
    end

endmodule

// File: rtl/inc_seq_step.sv
// One symbol step of the checker: given the lock state and expected
// position before this symbol, returns the state after it, a mismatch
// flag and a frame-complete flag. Purely combinational; chained per lane.
module inc_seq_step
    import inc_seq_pkg::*;
(
    input  logic             in_lock,
    input  logic [IDX_W-1:0] in_exp,
    input  sym_t             rx,
    output logic             out_lock,
    output logic [IDX_W-1:0] out_exp,
    output logic             mis,
    output logic             done
);

    sym_t exp_sym;
    logic is_comma;

    // Compare the symbol with the expected frame position and advance.
    always_comb begin
        exp_sym  = sym_at(in_exp);
        is_comma = rx.k && (rx.v == K_COMMA);
        out_lock = 1'b0;
        out_exp  = '0;
        mis      = 1'b0;
        done     = 1'b0;
        if (!in_lock) begin
            if (is_comma) begin
                out_lock = 1'b1;
                out_exp  = IDX_W'(1);
            end
        end else if (rx == exp_sym) begin
            out_lock = 1'b1;
            done     = (in_exp == IDX_W'(LAST_POS));
            out_exp  = done ? '0 : in_exp + IDX_W'(1);
        end else begin
            mis = 1'b1;
            if (is_comma) begin
                out_lock = 1'b1;
                out_exp  = IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/inc_seq_chk.sv
// Checker: chains one step per lane (lane 0 first) and registers lock,
// the expected position, the error pulse and the clean-frame counter.
// Assumes LANES is far below FRAME_LEN, so at most one frame ends per cycle.
module inc_seq_chk
    import inc_seq_pkg::*;
#(
    parameter int LANES = 1,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*SYM_W-1:0] rx_data,
    input  logic [LANES-1:0]       rx_ctrl,
    output logic                   lock,
    output logic                   err,
    output logic [CNT_W-1:0]       frames
);

    logic             lock_q;
    logic [IDX_W-1:0] exp_q;
    logic             err_q;
    logic [CNT_W-1:0] frames_q;

    logic             lock_c [LANES+1];
    logic [IDX_W-1:0] exp_c  [LANES+1];
    logic [LANES-1:0] mis_l;
    logic [LANES-1:0] done_l;

    assign lock_c[0] = lock_q;
    assign exp_c[0]  = exp_q;

    for (genvar l = 0; l < LANES; l++) begin : g_step
        sym_t rx;
        assign rx = {rx_ctrl[l], rx_data[l*SYM_W +: SYM_W]};
        inc_seq_step u_step (
            .in_lock  (lock_c[l]),
            .in_exp   (exp_c[l]),
            .rx       (rx),
            .out_lock (lock_c[l+1]),
            .out_exp  (exp_c[l+1]),
            .mis      (mis_l[l]),
            .done     (done_l[l])
        );
    end

    // Register the state after the last lane, the error pulse and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            exp_q    <= '0;
            err_q    <= 1'b0;
            frames_q <= '0;
        end else begin
            lock_q <= lock_c[LANES];
            exp_q  <= exp_c[LANES];
            err_q  <= |mis_l;
            if (|done_l) begin
                frames_q <= frames_q + CNT_W'(1);
            end
        end
    end

    assign lock   = lock_q;
    assign err    = err_q;
    assign frames = frames_q;

endmodule

// File: rtl/inc_seq.sv
// Top: test-frame generator and checker side by side; they share only
// the clock and reset, so the checker may take any decoded stream.
module inc_seq
    import inc_seq_pkg::*;
#(
    parameter int LANES = 1,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [LANES*SYM_W-1:0] gen_data,
    output logic [LANES-1:0]       gen_ctrl,
    input  logic [LANES*SYM_W-1:0] chk_data,
    input  logic [LANES-1:0]       chk_ctrl,
    output logic                   chk_lock,
    output logic                   chk_err,
    output logic [CNT_W-1:0]       chk_frames
);

    inc_seq_gen #(.LANES(LANES)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .data  (gen_data),
        .ctrl  (gen_ctrl)
    );

    inc_seq_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_data (chk_data),
        .rx_ctrl (chk_ctrl),
        .lock    (chk_lock),
        .err     (chk_err),
        .frames  (chk_frames)
    );

endmodule

// File: rtl/inc_seq_sva.sv
// Assertion checker bound to inc_seq: relates the checker outputs to the
// commas seen at its input and the generator ramp across cycles.
module inc_seq_sva
    import inc_seq_pkg::*;
#(
    parameter int LANES = 1,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SYM_W-1:0]       gen_lo,
    input logic                   gen_k0,
    input logic [LANES*SYM_W-1:0] chk_data,
    input logic [LANES-1:0]       chk_ctrl,
    input logic                   chk_lock,
    input logic                   chk_err,
    input logic [CNT_W-1:0]       chk_frames
);

    logic started_q;
    logic comma_in;

    // Marks that one clock has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // Any lane of the checker input carries a comma.
    always_comb begin
        comma_in = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (chk_ctrl[l] && chk_data[l*SYM_W +: SYM_W] == K_COMMA) comma_in = 1'b1;
        end
    end

    // R7
    frames_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (chk_frames == $past(chk_frames) ||
                       chk_frames == $past(chk_frames) + CNT_W'(1)));

    // R7
    frames_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && chk_frames != $past(chk_frames)) |-> chk_lock);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && chk_lock && !$past(chk_lock)) |-> $past(comma_in));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && chk_err && chk_lock) |-> $past(comma_in));

    // R2
    gen_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !gen_k0 && !$past(gen_k0)) |->
            gen_lo == $past(gen_lo) + SYM_W'(LANES));

endmodule

bind inc_seq inc_seq_sva #(.LANES(LANES), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_lo     (gen_data[7:0]),
    .gen_k0     (gen_ctrl[0]),
    .chk_data   (chk_data),
    .chk_ctrl   (chk_ctrl),
    .chk_lock   (chk_lock),
    .chk_err    (chk_err),
    .chk_frames (chk_frames)
);

// File: tb/inc_seq_bench.sv
// Bench: a single-lane and a two-lane instance. Generator outputs are
// swept every cycle; checker inputs come from a bench-side frame model.
module inc_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0]  s_data = '0;
    logic        s_ctrl = 1'b0;
    logic [15:0] d_data = '0;
    logic [1:0]  d_ctrl = '0;

    logic [7:0]  g1_data;
    logic        g1_ctrl;
    logic [15:0] g2_data;
    logic [1:0]  g2_ctrl;
    logic        l1, e1, l2, e2;
    logic [15:0] f1, f2;

    int nchk = 0;
    int nfail = 0;
    int ncyc = 0;
    bit run_gen = 0;

    inc_seq #(.LANES(1), .CNT_W(16)) u_inc_seq (
        .clk(clk), .rst_n(rst_n), .gen_data(g1_data), .gen_ctrl(g1_ctrl),
        .chk_data(s_data), .chk_ctrl(s_ctrl),
        .chk_lock(l1), .chk_err(e1), .chk_frames(f1)
    );

    inc_seq #(.LANES(2), .CNT_W(16)) u_inc_seq_w2 (
        .clk(clk), .rst_n(rst_n), .gen_data(g2_data), .gen_ctrl(g2_ctrl),
        .chk_data(d_data), .chk_ctrl(d_ctrl),
        .chk_lock(l2), .chk_err(e2), .chk_frames(f2)
    );

    // Frame model from R2: {flag, value} at any stream position.
    function automatic logic [8:0] ref_sym(input int i);
        int p = i % 268;
        if (p == 0) return {1'b1, 8'hBC};
        if (p == 1) return {1'b1, 8'hFB};
        if (p < 258) return {1'b0, 8'(p - 2)};
        case (p - 258)
            0: return {1'b1, 8'h1C};
            1: return {1'b1, 8'h3C};
            2: return {1'b1, 8'h5C};
            3: return {1'b1, 8'h7C};
            4: return {1'b1, 8'h9C};
            5: return {1'b1, 8'hDC};
            6: return {1'b1, 8'hFC};
            7: return {1'b1, 8'hF7};
            8: return {1'b1, 8'hFE};
            default: return {1'b1, 8'hFD};
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    task automatic put1(input logic [8:0] x);
        {s_ctrl, s_data} = x;
    endtask

    task automatic put2(input logic [8:0] lo, input logic [8:0] hi);
        d_ctrl = {hi[8], lo[8]};
        d_data = {hi[7:0], lo[7:0]};
    endtask

    task automatic expect1(input string req, input bit lk, input bit er, input int fr);
        check({req, " lock"}, int'(l1), int'(lk));
        check({req, " err"}, int'(e1), int'(er));
        check({req, " frames"}, int'(f1), fr);
    endtask

    task automatic expect2(input string req, input bit lk, input bit er, input int fr);
        check({req, " lock2"}, int'(l2), int'(lk));
        check({req, " err2"}, int'(e2), int'(er));
        check({req, " frames2"}, int'(f2), fr);
    endtask

    // One clock, then sample settled outputs; generators are swept each cycle.
    task automatic cyc();
        @(posedge clk);
        #2;
        ncyc++;
        if (run_gen) begin
            check("R2 gen1", int'({g1_ctrl, g1_data}), int'(ref_sym(ncyc)));
            check("R3 gen2 low", int'({g2_ctrl[0], g2_data[7:0]}), int'(ref_sym(2*ncyc)));
            check("R3 gen2 high", int'({g2_ctrl[1], g2_data[15:8]}), int'(ref_sym(2*ncyc + 1)));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: state right after reset, before any edge.
        check("R1 gen1", int'({g1_ctrl, g1_data}), 'h1BC);
        check("R1 gen2 low", int'({g2_ctrl[0], g2_data[7:0]}), 'h1BC);
        expect1("R1", 1'b0, 1'b0, 0);
        expect2("R1", 1'b0, 1'b0, 0);
        run_gen = 1;

        // R4: garbage incl. 0xBC with flag 0 and non-comma codes never locks.
        for (int i = 0; i < 300; i++) begin
            if (i % 3 == 0) put1({1'b1, 8'hFB});
            else            put1({1'b0, 8'(i)});
            cyc();
            expect1("R4", 1'b0, 1'b0, 0);
        end
        put1({1'b0, 8'hBC});
        cyc();
        expect1("R4 flag0 comma", 1'b0, 1'b0, 0);

        // R5 R7: three clean frames.
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < 268; k++) begin
                put1(ref_sym(k));
                cyc();
                expect1("R5 R7 clean", 1'b1, 1'b0, f + ((k == 267) ? 1 : 0));
            end
        end

        // R6 R7: corrupt data value at k=100; frame not counted; relock next frame.
        for (int k = 0; k < 268; k++) begin
            put1((k == 100) ? (ref_sym(k) ^ 9'h001) : ref_sym(k));
            cyc();
            expect1("R6 corrupt", (k < 100) ? 1'b1 : 1'b0, (k == 100) ? 1'b1 : 1'b0, 3);
        end
        for (int k = 0; k < 268; k++) begin
            put1(ref_sym(k));
            cyc();
            expect1("R6 relock", 1'b1, 1'b0, 3 + ((k == 267) ? 1 : 0));
        end

        // R9: flag-only error on the first closing code.
        for (int k = 0; k < 268; k++) begin
            put1((k == 258) ? {1'b0, 8'h1C} : ref_sym(k));
            cyc();
            expect1("R9 flag", (k < 258) ? 1'b1 : 1'b0, (k == 258) ? 1'b1 : 1'b0, 4);
        end

        // R6: stray comma while locked raises error but keeps lock.
        for (int k = 0; k < 50; k++) begin
            put1(ref_sym(k));
            cyc();
            expect1("R6 pre", 1'b1, 1'b0, 4);
        end
        put1({1'b1, 8'hBC});
        cyc();
        expect1("R6 stray comma", 1'b1, 1'b1, 4);
        for (int k = 1; k < 268; k++) begin
            put1(ref_sym(k));
            cyc();
            expect1("R6 after comma", 1'b1, 1'b0, 4 + ((k == 267) ? 1 : 0));
        end
        put1(9'h000);

        // R8 R3: two-lane aligned stream, two frames.
        for (int n = 0; n < 268; n++) begin
            put2(ref_sym(2*n), ref_sym(2*n + 1));
            cyc();
            expect2("R8 aligned", 1'b1, 1'b0, (2*n + 2) / 268);
        end

        // R8 R6: skew by one; comma in high lane after a bad low lane.
        put2({1'b0, 8'h55}, ref_sym(0));
        cyc();
        expect2("R8 skew comma high", 1'b1, 1'b1, 2);
        for (int m = 1; m <= 300; m++) begin
            put2(ref_sym(2*m - 1), ref_sym(2*m));
            cyc();
            expect2("R8 skew", 1'b1, 1'b0, 2 + (2*m + 1) / 268);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule